// File: doc/BRIEF.md
# Current-Mode PWM Gate Control Core

This block is the digital heart of a single-ended current-mode switching controller. An oscillator square wave enters as a digital level. The block halves its frequency to form the switching period. Only the first oscillator period of each switching period may carry an on-pulse, so the duty cycle can never exceed one half.

A set/reset PWM latch sets at the start of each switching period. It clears when the current-mode comparator flag or the current-limit flag asserts, or when the on-window closes. The gate-drive enable is further qualified by an undervoltage flag and by an override pair of active-low pins. The shutdown pin forces the output off while it is low. If the rearm pin is also low at the same time, an off-latch is set, and it holds the output off until the rearm pin returns high.

All asynchronous inputs pass through multi-flop synchronisers before use. After any blocking condition ends, the output stays low until the next switching-period start. This avoids a truncated first pulse.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, `gate_en` is low, the divider and the PWM latch are cleared, and the off-latch is cleared. After release, `gate_en` stays low until the first switching-period start.
- R2: Every second rising edge of the synchronised oscillator starts a switching period. `gate_en` can be high only during the oscillator period that follows such a start, so with a symmetric oscillator it is never high for more than half of a switching period.
- R3: With no trip, no undervoltage and both override pins high, `gate_en` rises at each switching-period start and falls at the next oscillator rising edge.
- R4: When the synchronised `cm_trip` is high, `gate_en` is low on the following clock. It stays low until the next switching-period start.
- R5: `ilim_trip` ends the on-pulse in the same way as `cm_trip`, whatever the state of `cm_trip`.
- R6: While the synchronised `uv_low` is 1 (supply below threshold), `gate_en` is low on the following clock.
- R7: While `shdn_n` is low and `rearm_n` is high, `gate_en` is off. The off state is not latched: normal pulses resume once `shdn_n` is high again.
- R8: If `shdn_n` and `rearm_n` are low together for at least 3 clocks, the off-latch sets. `gate_en` then stays low, whatever `shdn_n` does, until `rearm_n` goes high.
- R9: `rearm_n` high clears the off-latch. With `shdn_n` high and `rearm_n` low, the latch state is kept, so an unlatched block keeps switching normally.
- R10: After an undervoltage, shutdown or off-latch condition ends, `gate_en` rises only at a switching-period start, never in the middle of an on-window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| osc_in | input | 1 | Oscillator square wave, asynchronous |
| cm_trip | input | 1 | Current-mode comparator tripped, active high |
| ilim_trip | input | 1 | Current-limit comparator tripped, active high |
| uv_low | input | 1 | Supply below undervoltage threshold, active high |
| shdn_n | input | 1 | Active-low shutdown override pin |
| rearm_n | input | 1 | Active-low rearm pin; low together with shutdown latches off |
| gate_en | output | 1 | Gate-drive enable |

## Verification
A wrong divider phase shows at the ports within one switching period: pulses appear in the wrong oscillator half or run longer than one oscillator period. A stale PWM latch shows as a pulse that continues past a trip flag, one clock after the synchronised trip. A wrong off-latch state only appears once `shdn_n` returns high while `rearm_n` is still low. The bench therefore holds that combination for several switching periods, then checks that pulses resume within one period after `rearm_n` rises.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

    // Synchroniser bank layout
    localparam int unsigned SYNC_W   = 6;
    localparam int unsigned IDX_OSC  = 5;
    localparam int unsigned IDX_CM   = 4;
    localparam int unsigned IDX_ILIM = 3;
    localparam int unsigned IDX_UV   = 2;
    localparam int unsigned IDX_SHDN = 1;
    localparam int unsigned IDX_REARM = 0;

    // Safe idle values: undervoltage asserted, override pins released
    localparam logic [SYNC_W-1:0] SYNC_IDLE = 6'b000111;

    typedef struct packed {
        logic phase;
        logic osc_prev;
    } div_state_t;

    typedef struct packed {
        logic off_latched;
    } ovr_state_t;

    typedef struct packed {
        logic pwm;
    } core_state_t;

endpackage

// File: rtl/pwm_sync_bank.sv
module pwm_sync_bank #(
    parameter int unsigned     WIDTH   = 6,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pwm_osc_div.sv
module pwm_osc_div
    import pwm_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic osc_i,
    output logic phase_o,
    output logic start_o,
    output logic stop_o
);

    div_state_t state_d, state_q;
    logic       rise;

    always_comb begin
        rise           = osc_i & ~state_q.osc_prev;
        state_d        = state_q;
        state_d.osc_prev = osc_i;
        state_d.phase  = state_q.phase ^ rise;
        start_o        = rise & ~state_q.phase;
        stop_o         = rise & state_q.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign phase_o = state_q.phase;

endmodule

// File: rtl/pwm_override_latch.sv
module pwm_override_latch
    import pwm_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_n_i,
    input  logic rearm_n_i,
    output logic latched_o
);

    ovr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!shdn_n_i && !rearm_n_i) begin
            state_d.off_latched = 1'b1;
        end else if (rearm_n_i) begin
            state_d.off_latched = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign latched_o = state_q.off_latched;

endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl
    import pwm_gate_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    input  logic cm_trip,
    input  logic ilim_trip,
    input  logic uv_low,
    input  logic shdn_n,
    input  logic rearm_n,
    output logic gate_en
);

    logic [SYNC_W-1:0] raw_vec, syn_vec;
    logic osc_s, cm_s, ilim_s, uv_s, shdn_n_s, rearm_n_s;
    logic phase, period_start, window_end;
    logic off_latched, blocked;

    core_state_t core_d, core_q;

    always_comb begin
        raw_vec            = '0;
        raw_vec[IDX_OSC]   = osc_in;
        raw_vec[IDX_CM]    = cm_trip;
        raw_vec[IDX_ILIM]  = ilim_trip;
        raw_vec[IDX_UV]    = uv_low;
        raw_vec[IDX_SHDN]  = shdn_n;
        raw_vec[IDX_REARM] = rearm_n;
    end

    pwm_sync_bank #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(raw_vec),
        .sync_o (syn_vec)
    );

    assign osc_s     = syn_vec[IDX_OSC];
    assign cm_s      = syn_vec[IDX_CM];
    assign ilim_s    = syn_vec[IDX_ILIM];
    assign uv_s      = syn_vec[IDX_UV];
    assign shdn_n_s  = syn_vec[IDX_SHDN];
    assign rearm_n_s = syn_vec[IDX_REARM];

    pwm_osc_div u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_i  (osc_s),
        .phase_o(phase),
        .start_o(period_start),
        .stop_o (window_end)
    );

    pwm_override_latch u_ovr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shdn_n_i (shdn_n_s),
        .rearm_n_i(rearm_n_s),
        .latched_o(off_latched)
    );

    // Reset of the PWM latch dominates its set input
    always_comb begin
        blocked = uv_s | ~shdn_n_s | off_latched;
        core_d  = core_q;
        if (blocked || cm_s || ilim_s) begin
            core_d.pwm = 1'b0;
        end else if (period_start) begin
            core_d.pwm = 1'b1;
        end else if (window_end) begin
            core_d.pwm = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign gate_en = core_q.pwm;

endmodule

// File: rtl/pwm_gate_ctrl_chk.sv
module pwm_gate_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic gate,
    input logic phase,
    input logic off_latched,
    input logic uv_s,
    input logic shdn_n_s,
    input logic cm_s,
    input logic ilim_s
);

    assert_gate_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> phase);

    assert_cm_ends_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cm_s |=> !gate);

    assert_ilim_ends_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_s |=> !gate);

    assert_uv_holds_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> !gate);

    assert_shdn_holds_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n_s |=> !gate);

    assert_latch_holds_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        off_latched |-> !gate);

    assert_rise_at_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> (phase && !$past(phase)));

endmodule

bind pwm_gate_ctrl pwm_gate_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate       (gate_en),
    .phase      (phase),
    .off_latched(off_latched),
    .uv_s       (uv_s),
    .shdn_n_s   (shdn_n_s),
    .cm_s       (cm_s),
    .ilim_s     (ilim_s)
);

// File: tb/pwm_gate_ctrl_test.sv
`timescale 1ns/1ps
module pwm_gate_ctrl_test;

    localparam int OSC_HALF = 4;
    localparam int WATCHDOG = 50000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc = 1'b0, cm = 1'b0, ilim = 1'b0, uv = 1'b1, shdn_n = 1'b1, rearm_n = 1'b1;
    logic gate_en;

    int total = 0, bad = 0, cyc = 0, osc_cnt = 0;
    int rises = 0, run_len = 0;
    logic prev_gate = 1'b0;
    bit done = 0;
    string cur_req = "R1";

    // Reference model state
    logic [5:0] hist[$];
    logic m_prev = 0, m_phase = 0, m_pwm = 0, m_latch = 0;

    always #5 clk = ~clk;

    pwm_gate_ctrl uut (
        .clk(clk), .rst_n(rst_n), .osc_in(osc), .cm_trip(cm), .ilim_trip(ilim),
        .uv_low(uv), .shdn_n(shdn_n), .rearm_n(rearm_n), .gate_en(gate_en)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic check_int(input string req, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural model: inputs delayed by two clocks, then applied
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist.delete();
            m_prev = 0; m_phase = 0; m_pwm = 0; m_latch = 0;
        end else begin
            logic [5:0] s;
            logic rise, blk;
            hist.push_back({osc, cm, ilim, uv, shdn_n, rearm_n});
            if (hist.size() > 2) s = hist.pop_front();
            else s = 6'b000111;
            rise = s[5] && !m_prev;
            blk = s[2] || !s[1] || m_latch;
            if (blk || s[4] || s[3]) m_pwm = 0;
            else if (rise && !m_phase) m_pwm = 1;
            else if (rise && m_phase) m_pwm = 0;
            if (!s[1] && !s[0]) m_latch = 1;
            else if (s[0]) m_latch = 0;
            if (rise) m_phase = !m_phase;
            m_prev = s[5];
        end
    end

    // Per-cycle comparison and monitors
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, gate_en, m_pwm);
            if (gate_en && !prev_gate) rises++;
            if (gate_en) run_len++;
            else begin
                if (run_len > 0)
                    check_int("R2 on-run length", run_len <= 2*OSC_HALF, run_len, 2*OSC_HALF);
                run_len = 0;
            end
            prev_gate = gate_en;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            osc_cnt++;
            if (osc_cnt == OSC_HALF) begin
                osc = ~osc;
                osc_cnt = 0;
            end
        end
    endtask

    initial begin
        tick(4);
        check("R1 reset", gate_en, 1'b0);
        rst_n = 1'b1;
        tick(10);
        check("R1 low while uv", gate_en, 1'b0);

        // Nominal switching
        cur_req = "R3"; uv = 1'b0; rises = 0;
        tick(64);
        check_int("R3 pulses in nominal run", rises >= 3, rises, 3);

        // Current-mode trips at varied offsets
        cur_req = "R4";
        for (int i = 0; i < 64; i++) begin
            cm = (i % 16 == 3) || (i % 23 == 7);
            tick(1);
        end
        cm = 1'b0;

        // Current-limit trips, cm idle and also together with cm
        cur_req = "R5";
        for (int i = 0; i < 64; i++) begin
            ilim = (i % 16 == 2) || (i % 19 == 5);
            cm = (i % 32 == 2);
            tick(1);
        end
        ilim = 1'b0; cm = 1'b0;

        // Undervoltage in mid-window, release at odd offset
        cur_req = "R6"; tick(5); uv = 1'b1; tick(21);
        cur_req = "R10"; uv = 1'b0; tick(48);

        // Unlatched shutdown
        cur_req = "R7"; tick(3); shdn_n = 1'b0; tick(11);
        shdn_n = 1'b1; rises = 0; tick(48);
        check_int("R7 resumes after unlatched shutdown", rises >= 2, rises, 2);

        // Latched off: 3-clock overlap, then shutdown released
        cur_req = "R8"; tick(2);
        shdn_n = 1'b0; rearm_n = 1'b0; tick(3);
        shdn_n = 1'b1; tick(4); rises = 0; tick(60);
        check_int("R8 latched off keeps gate low", rises == 0, rises, 0);
        shdn_n = 1'b0; tick(5); shdn_n = 1'b1; tick(20);
        check_int("R8 shdn toggles ignored", rises == 0, rises, 0);

        // Rearm clears the latch
        cur_req = "R9"; rearm_n = 1'b1; rises = 0; tick(48);
        check_int("R9 pulses after rearm", rises >= 2, rises, 2);
        rearm_n = 1'b0; rises = 0; tick(48);
        check_int("R9 rearm low alone keeps switching", rises >= 2, rises, 2);
        rearm_n = 1'b1;

        // Block reset clears a set off-latch
        cur_req = "R1"; shdn_n = 1'b0; rearm_n = 1'b0; tick(4);
        rst_n = 1'b0; tick(1);
        check("R1 gate low in reset", gate_en, 1'b0);
        shdn_n = 1'b1; rearm_n = 1'b1; tick(2);
        rst_n = 1'b1; rises = 0; tick(48);
        check_int("R1 latch cleared by reset", rises >= 2, rises, 2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule